// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Interface

This block is the digital front end of a two-channel 12-bit converter. A host shifts a 24-bit word into a serial chain one bit per falling edge of a slow serial clock. Bits are accepted only while an active-low chip select is held low. The last bit of the chain is driven out on a serial data output, so several such blocks can share one bit stream in a daisy chain.

Each channel has its own active-low load input. While a load input is low, that channel's held code follows its half of the chain. When the load input goes high, the code freezes. Channel B takes the upper half, which holds the first twelve bits received. Channel A takes the lower half, which holds the last twelve. Driving both load inputs low updates both channels at once.

An active-low clear empties the chain. It also forces both held codes to the zero point selected by a mode pin: unipolar zero or mid-scale bipolar zero. All serial-side inputs are sampled in a fast system-clock domain. The clear is asserted asynchronously into a synchronizer and released synchronously.

Top module: `dual_dac_serial_if`

## Requirements
- R1: On each falling edge of `sclk` seen while `cs_n` is low, the chain shifts up by one place and `sdin` enters the least significant place.
- R2: After 24 accepted bits followed by a load of both channels, `code_b` equals the first 12 bits received, first bit as its bit 11. `code_a` equals the last 12 bits, last bit as its bit 0.
- R3: While `ld_a_n` is low, `code_a` tracks the lower 12 bits of the chain. Once `ld_a_n` is high, `code_a` keeps its value through further shifting.
- R4: `ld_b_n` controls `code_b` alone and `ld_a_n` controls `code_a` alone. Loading one channel leaves the other unchanged.
- R5: `sdout` is bit 23 of the chain, which is the bit accepted 24 shifts earlier.
- R6: While `cs_n` is high, serial clock edges change neither the chain, `sdout` nor the held codes.
- R7: While clear is active, the chain is all zero. Both codes read 12'h000 when `zero_sel` is 0 and 12'h800 when `zero_sel` is 1.
- R8: Clear overrides shifting and loading, even while a load input is low. A load after clear is released transfers 12'h000 from the emptied chain.
- R9: After system reset is released, both codes read the zero point chosen by `zero_sel` and `sdout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Asynchronous active-low clear |
| zero_sel | input | 1 | Zero point on clear: 0 unipolar (000h), 1 bipolar (800h) |
| sclk | input | 1 | Serial clock; data accepted on its falling edge |
| cs_n | input | 1 | Active-low chip select |
| sdin | input | 1 | Serial data in, first bit goes to channel B MSB |
| ld_a_n | input | 1 | Active-low level load for channel A |
| ld_b_n | input | 1 | Active-low level load for channel B |
| sdout | output | 1 | Serial data out, top bit of the chain |
| code_a | output | 12 | Held code of channel A |
| code_b | output | 12 | Held code of channel B |

## Verification
The properties assume that `zero_sel` is steady while clear is active. They also assume that each `sclk` phase and each load pulse lasts longer than the synchronizer depth plus one system clock. `sdin` and `cs_n` must settle before the serial edge that uses them. The stimulus holds each serial clock phase for four system cycles and every load or clear pulse for six. All inputs change on the falling edge of the system clock, so no sample is taken while an input is moving. Because a clear can arrive between system edges, the stability and tracking properties accept a cycle in which clear has just taken over.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
package dsd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    ZERO_UNIPOLAR = 1'b0,
    ZERO_BIPOLAR  = 1'b1
  } zero_mode_e;
endpackage

// File: rtl/dsd_sync.sv
`timescale 1ns/1ps
module dsd_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dsd_clr_sync.sv
`timescale 1ns/1ps
module dsd_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clr_act
);
  logic              arst_n;
  logic [STAGES-1:0] hold_q;
  logic [STAGES-1:0] hold_d;

  assign arst_n = rst_n & clr_n;

  always_comb begin
    hold_d = {hold_q[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) hold_q <= '1;
    else         hold_q <= hold_d;
  end

  assign clr_act = hold_q[STAGES-1];
endmodule

// File: rtl/dsd_shift_chain.sv
`timescale 1ns/1ps
module dsd_shift_chain #(
  parameter int CHAIN_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_act,
  input  logic               shift_en,
  input  logic               sdin,
  output logic [CHAIN_W-1:0] chain
);
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = chain;
    if (clr_act)       chain_d = '0;
    else if (shift_en) chain_d = {chain[CHAIN_W-2:0], sdin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_d;
  end
endmodule

// File: rtl/dsd_hold_reg.sv
`timescale 1ns/1ps
module dsd_hold_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_act,
  input  logic [W-1:0] clr_val,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr_act)   q_d = clr_val;
    else if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/dual_dac_serial_if.sv
`timescale 1ns/1ps
module dual_dac_serial_if #(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              zero_sel,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdin,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  output logic              sdout,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  import dsd_pkg::*;

  localparam int                CHAIN_W  = NUM_CH * CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  // Input order: {sclk, cs_n, sdin, ld_b_n, ld_a_n}
  localparam logic [4:0] IN_RST = 5'b01011;

  logic [4:0]               raw_in;
  logic [4:0]               syn_in;
  logic                     sclk_s;
  logic                     cs_s;
  logic                     sdin_s;
  logic [NUM_CH-1:0]        ld_s;
  logic                     sclk_d;
  logic                     fall;
  logic                     shift_en;
  logic                     clr_act;
  logic [CHAIN_W-1:0]       chain;
  logic [CODE_W-1:0]        zero_val;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;
  zero_mode_e               zmode;

  assign raw_in = {sclk, cs_n, sdin, ld_b_n, ld_a_n};

  dsd_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign sclk_s = syn_in[4];
  assign cs_s   = syn_in[3];
  assign sdin_s = syn_in[2];
  assign ld_s   = syn_in[1:0];

  dsd_clr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .clr_act (clr_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign fall     = sclk_d & ~sclk_s;
  assign shift_en = fall & ~cs_s;

  dsd_shift_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_act  (clr_act),
    .shift_en (shift_en),
    .sdin     (sdin_s),
    .chain    (chain)
  );

  assign zmode    = zero_mode_e'(zero_sel);
  assign zero_val = (zmode == ZERO_BIPOLAR) ? MID_CODE : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dsd_hold_reg #(.W(CODE_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_act (clr_act),
      .clr_val (zero_val),
      .load    (~ld_s[ch]),
      .d       (chain[ch*CODE_W +: CODE_W]),
      .q       (codes[ch])
    );
  end

  assign code_a = codes[0];
  assign code_b = codes[1];
  assign sdout  = chain[CHAIN_W-1];
endmodule

// File: rtl/dsd_checker.sv
`timescale 1ns/1ps
module dsd_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_act,
  input logic              shift_en,
  input logic              ld_a_s,
  input logic              ld_b_s,
  input logic              zero_sel,
  input logic [CODE_W-1:0] chain_lo,
  input logic              chain_nxt_top,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              sdout
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  p_clear_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (code_a == ($past(zero_sel) ? MID : '0)) &&
                (code_b == ($past(zero_sel) ? MID : '0)));

  p_clear_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (sdout == 1'b0));

  p_freeze_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && ld_a_s) |=> (clr_act || $stable(code_a)));

  p_freeze_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && ld_b_s) |=> (clr_act || $stable(code_b)));

  p_track_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ld_a_s) |=> (clr_act || code_a == $past(chain_lo)));

  p_shift_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && shift_en) |=> (clr_act || sdout == $past(chain_nxt_top)));

  p_no_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !shift_en) |=> (clr_act || $stable(sdout)));
endmodule

bind dual_dac_serial_if dsd_checker #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_act       (clr_act),
  .shift_en      (shift_en),
  .ld_a_s        (ld_s[0]),
  .ld_b_s        (ld_s[1]),
  .zero_sel      (zero_sel),
  .chain_lo      (chain[CODE_W-1:0]),
  .chain_nxt_top (chain[CHAIN_W-2]),
  .code_a        (code_a),
  .code_b        (code_b),
  .sdout         (sdout)
);

// File: tb/dual_dac_serial_if_tb.sv
`timescale 1ns/1ps
module dual_dac_serial_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, clr_n, zero_sel, sclk, cs_n, sdin, ld_a_n, ld_b_n;
  logic        sdout;
  logic [11:0] code_a, code_b;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          finished = 0;

  dual_dac_serial_if dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .zero_sel(zero_sel),
    .sclk(sclk), .cs_n(cs_n), .sdin(sdin), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
    .sdout(sdout), .code_a(code_a), .code_b(code_b)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [23:0] w, input logic sel);
    cs_n = ~sel;
    for (int i = 0; i < 24; i++) begin
      sdin = w[23-i];
      sclk = 1'b1;
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(4);
    end
    wait_cyc(4);
    cs_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic pulse_ld(input logic a, input logic b);
    ld_a_n = ~a;
    ld_b_n = ~b;
    wait_cyc(6);
    ld_a_n = 1'b1;
    ld_b_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic do_clear;
    clr_n = 1'b0;
    wait_cyc(6);
    clr_n = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    logic [11:0] exp_a, exp_b;
    logic        s_prev;
    rst_n = 0; clr_n = 1; zero_sel = 1; sclk = 0; cs_n = 1; sdin = 0;
    ld_a_n = 1; ld_b_n = 1;
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(8);
    // R9: bipolar zero after reset
    chk("R9 code_a", code_a, 12'h800);
    chk("R9 code_b", code_b, 12'h800);
    chk("R9 sdout", sdout, 0);

    // R7: unipolar clear
    zero_sel = 0;
    do_clear();
    chk("R7 code_a", code_a, 12'h000);
    chk("R7 code_b", code_b, 12'h000);

    // R1 R2 R5
    shift_word(24'hABC123, 1);
    chk("R5 sdout", sdout, 1);
    pulse_ld(1, 1);
    chk("R2 code_b", code_b, 12'hABC);
    chk("R1 R2 code_a", code_a, 12'h123);

    // R6: deselected clocks ignored
    s_prev = sdout;
    shift_word(24'hFFFFFF, 0);
    chk("R6 sdout", sdout, s_prev);
    chk("R6 code_a", code_a, 12'h123);
    pulse_ld(1, 1);
    chk("R6 chain_b", code_b, 12'hABC);
    chk("R6 chain_a", code_a, 12'h123);

    // R3: transparent while low, frozen when high
    ld_a_n = 0;
    shift_word(24'h555AAA, 1);
    chk("R3 track", code_a, 12'hAAA);
    chk("R4 b_held", code_b, 12'hABC);
    ld_a_n = 1;
    wait_cyc(6);
    shift_word(24'h0F0F0F, 1);
    chk("R3 frozen", code_a, 12'hAAA);
    pulse_ld(0, 1);
    chk("R4 b_only", code_b, 12'h0F0);
    chk("R4 a_kept", code_a, 12'hAAA);

    // R2 R4 R5 sweep over patterns and load choices
    exp_a = code_a;
    exp_b = code_b;
    for (int i = 0; i < 40; i++) begin
      if (i == 0)      w = 24'h000000;
      else if (i == 1) w = 24'hFFFFFF;
      else             w = 24'((i * 32'h002F1A57) + 32'h13);
      shift_word(w, 1);
      chk("R5 sweep sdout", sdout, w[23]);
      case (i % 3)
        0: begin pulse_ld(1, 1); exp_a = w[11:0]; exp_b = w[23:12]; end
        1: begin pulse_ld(1, 0); exp_a = w[11:0]; end
        default: begin pulse_ld(0, 1); exp_b = w[23:12]; end
      endcase
      chk("R2 R4 sweep a", code_a, exp_a);
      chk("R2 R4 sweep b", code_b, exp_b);
    end

    // R8: clear wins over a held-low load, then load gets 000
    zero_sel = 1;
    ld_a_n = 0;
    clr_n = 0;
    wait_cyc(8);
    chk("R8 clr_over_load", code_a, 12'h800);
    chk("R7 bipolar b", code_b, 12'h800);
    clr_n = 1;
    wait_cyc(8);
    chk("R8 after_release", code_a, 12'h000);
    ld_a_n = 1;
    wait_cyc(6);
    pulse_ld(0, 1);
    chk("R8 load_zero", code_b, 12'h000);
    chk("R7 chain_empty", sdout, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule